// File: doc/BRIEF.md
# Instruction Word Buffer Tracker

This block keeps track of which of a small set of instruction word buffers already hold words close to the current lookahead control counter, so that a word still present does not need a second core memory read. Each instruction word carries three control groups. The lookahead counter steps by one or two groups. A word always lives in the buffer whose index equals its word address modulo the buffer count. Instead of comparing address tags, every buffer carries two indicator bits. The "ahead" bit marks a word that lies within the next three higher word addresses. The "behind" bit marks the current word or a word within the three lower word addresses. Both bits are slid along as the counter moves.

On sequential flow the block decides hit or miss when the counter enters a new word. A taken jump is handled according to its word distance. A short jump slides the indicators by that distance, in either direction. A long jump discards all indicators. On a miss the block stalls the lookahead side and asks for a memory read of the current word. It waits first until the trailing execution control has left that buffer, so that the word being executed is never overwritten. Decoding instructions and performing the read itself happen outside the block.

Top module: `iword_buf_tracker`

## Requirements
- R1: After reset the counter is zero, every indicator bit is 0, `ready_o` is 1 and `fetch_req_o` is 0.
- R2: When `ready_o` is 1, an advance moves the counter by one group (`long_i`=0) or by two (`long_i`=1). The group field is bits [1:0] and takes only the values 0, 1 and 2; from 2 it rolls over to group 0 of the next word address.
- R3: When an advance enters a new word, that word's buffer (counter bits [3:2]) has its ahead bit copied into its behind bit, and its ahead bit cleared. The advance is a hit, and `ready_o` stays 1, exactly when the resulting behind bit is 1. In `ind_o`, bit 2b+1 is the ahead bit and bit 2b is the behind bit of buffer b.
- R4: After a miss, `ready_o` is 0. `fetch_req_o` rises only in the cycle after `exec_buf_i` differs from the current buffer index. While the request is active, `fetch_word_o` holds counter bits [14:2] and `fetch_buf_o` holds bits [3:2].
- R5: When `fetch_ack_i` is 1 during a request, the behind bit of the fetched buffer is set at that clock edge, and `ready_o` returns to 1.
- R6: A jump taken while `ready_o` is 1 loads `jump_cnt_i`. For a word difference d from +1 to +6 (modulo 2^13), the buffers cur+1 … cur+d (modulo 4) are visited in that order. Each visit copies the ahead bit into the behind bit and clears the ahead bit. The jump is a hit when the last visited buffer ends with behind bit 1.
- R7: For d from −1 to −6, the buffers cur−1 … cur−d are visited in that order. Each visit copies the behind bit into the ahead bit and clears the behind bit. The jump is a hit when the last visited buffer ends with ahead bit 1.
- R8: A jump with |d| greater than 6 clears every indicator bit and always misses, which leads to the wait and fetch of R4 and R5.
- R9: A jump with d = 0 changes only the counter and leaves all indicators and `ready_o` unchanged.
- R10: `start_i` takes priority in any state. It loads `start_cnt_i`, clears every indicator bit and raises `fetch_req_o` at the next edge, without waiting on `exec_buf_i`.
- R11: While `ready_o` is 0, `adv_i` and `jump_i` change neither the counter nor the indicators.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Restart at `start_cnt_i` |
| start_cnt_i | input | 15 | Counter value used at restart |
| adv_i | input | 1 | Advance the lookahead counter |
| long_i | input | 1 | Advance by two groups instead of one |
| jump_i | input | 1 | Taken jump to `jump_cnt_i` (priority over `adv_i`) |
| jump_cnt_i | input | 15 | Jump target counter value |
| exec_buf_i | input | 2 | Buffer index the execution control is working in |
| fetch_ack_i | input | 1 | Memory read into the buffer has completed |
| ready_o | output | 1 | Lookahead may proceed (no pending read) |
| la_cnt_o | output | 15 | Lookahead control counter |
| ind_o | output | 8 | Indicator bits, {ahead, behind} per buffer |
| fetch_req_o | output | 1 | Memory read requested |
| fetch_word_o | output | 13 | Word address to read |
| fetch_buf_o | output | 2 | Buffer to fill |

## Verification
The bench builds the block with its default parameters: a 15-bit counter, four buffers and a short-jump reach of six words. With only four buffers, every start buffer can be swept. So can every ordered pair of jump distances from −8 to +8. This covers shifts that wrap around the buffer ring and visit a buffer twice. It also covers the boundaries at ±6 and ±7, and the sign change between a forward and a backward slide. Each miss is held with the execution control parked on the same buffer, which shows the stall and the ignored advance and jump requests before the read is released.

// File: rtl/iwbt_pkg.sv
package iwbt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_FETCH = 2'd2
  } trk_state_e;
endpackage

// File: rtl/iwbt_cnt_step.sv
module iwbt_cnt_step #(
  parameter int CNT_W = 15
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             long_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             new_word_o
);
  localparam int WORD_W = CNT_W - 2;

  function automatic logic [CNT_W-1:0] step1(input logic [CNT_W-1:0] c);
    if (c[1:0] == 2'd2) step1 = {c[CNT_W-1:2] + WORD_W'(1), 2'b00};
    else                step1 = {c[CNT_W-1:2], c[1:0] + 2'd1};
  endfunction

  logic [CNT_W-1:0] one_q;

  always_comb begin
    one_q      = step1(cnt_i);
    cnt_o      = long_i ? step1(one_q) : one_q;
    new_word_o = (cnt_o[CNT_W-1:2] != cnt_i[CNT_W-1:2]);
  end
endmodule

// File: rtl/iwbt_ind_shift.sv
module iwbt_ind_shift #(
  parameter int NBUF     = 4,
  parameter int JUMP_MAX = 6,
  parameter int SEL_W    = $clog2(NBUF),
  parameter int DW       = $clog2(JUMP_MAX + 1)
) (
  input  logic [NBUF-1:0]  ahead_i,
  input  logic [NBUF-1:0]  behind_i,
  input  logic [SEL_W-1:0] base_i,
  input  logic             back_i,
  input  logic [DW-1:0]    mag_i,
  output logic [NBUF-1:0]  ahead_o,
  output logic [NBUF-1:0]  behind_o,
  output logic             hit_o
);
  logic [SEL_W-1:0] idx;
  logic [SEL_W-1:0] last;

  always_comb begin
    ahead_o  = ahead_i;
    behind_o = behind_i;
    idx      = base_i;
    last     = base_i;
    for (int k = 1; k <= JUMP_MAX; k++) begin
      if (k <= int'(mag_i)) begin
        idx = back_i ? base_i - SEL_W'(k) : base_i + SEL_W'(k);
        if (back_i) begin
          ahead_o[idx]  = behind_o[idx];
          behind_o[idx] = 1'b0;
        end else begin
          behind_o[idx] = ahead_o[idx];
          ahead_o[idx]  = 1'b0;
        end
        last = idx;
      end
    end
    if (mag_i == '0) hit_o = 1'b1;
    else if (back_i) hit_o = ahead_o[last];
    else             hit_o = behind_o[last];
  end
endmodule

// File: rtl/iword_buf_tracker.sv
module iword_buf_tracker #(
  parameter int CNT_W    = 15,
  parameter int NBUF     = 4,
  parameter int JUMP_MAX = 6,
  localparam int SEL_W   = $clog2(NBUF),
  localparam int WORD_W  = CNT_W - 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [CNT_W-1:0]   start_cnt_i,
  input  logic               adv_i,
  input  logic               long_i,
  input  logic               jump_i,
  input  logic [CNT_W-1:0]   jump_cnt_i,
  input  logic [SEL_W-1:0]   exec_buf_i,
  input  logic               fetch_ack_i,
  output logic               ready_o,
  output logic [CNT_W-1:0]   la_cnt_o,
  output logic [2*NBUF-1:0]  ind_o,
  output logic               fetch_req_o,
  output logic [WORD_W-1:0]  fetch_word_o,
  output logic [SEL_W-1:0]   fetch_buf_o
);
  import iwbt_pkg::*;
  localparam int DW = $clog2(JUMP_MAX + 1);

  trk_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [NBUF-1:0]  ahead_q, behind_q;

  logic [SEL_W-1:0] cur_buf;
  logic [CNT_W-1:0] step_cnt;
  logic             new_word;
  logic signed [WORD_W-1:0] jdiff;
  logic [WORD_W-1:0] jabs;
  logic             near;
  logic             sh_back;
  logic [DW-1:0]    sh_mag;
  logic [NBUF-1:0]  sh_ahead, sh_behind;
  logic             sh_hit;

  assign cur_buf = cnt_q[2 +: SEL_W];

  iwbt_cnt_step #(.CNT_W(CNT_W)) i_step (
    .cnt_i      (cnt_q),
    .long_i     (long_i),
    .cnt_o      (step_cnt),
    .new_word_o (new_word)
  );

  always_comb begin
    jdiff = signed'(jump_cnt_i[CNT_W-1:2] - cnt_q[CNT_W-1:2]);
    jabs  = (jdiff < 0) ? WORD_W'(-jdiff) : WORD_W'(jdiff);
    near  = (jabs <= WORD_W'(JUMP_MAX));
    if (jump_i) begin
      sh_back = (jdiff < 0);
      sh_mag  = near ? DW'(jabs) : '0;
    end else begin
      sh_back = 1'b0;
      sh_mag  = new_word ? DW'(1) : '0;
    end
  end

  iwbt_ind_shift #(.NBUF(NBUF), .JUMP_MAX(JUMP_MAX), .SEL_W(SEL_W), .DW(DW)) i_shift (
    .ahead_i  (ahead_q),
    .behind_i (behind_q),
    .base_i   (cur_buf),
    .back_i   (sh_back),
    .mag_i    (sh_mag),
    .ahead_o  (sh_ahead),
    .behind_o (sh_behind),
    .hit_o    (sh_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      ahead_q  <= '0;
      behind_q <= '0;
    end else if (start_i) begin
      cnt_q    <= start_cnt_i;
      ahead_q  <= '0;
      behind_q <= '0;
      state_q  <= ST_FETCH;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (jump_i) begin
            cnt_q <= jump_cnt_i;
            if (near) begin
              ahead_q  <= sh_ahead;
              behind_q <= sh_behind;
              state_q  <= sh_hit ? ST_IDLE : ST_WAIT;
            end else begin
              ahead_q  <= '0;
              behind_q <= '0;
              state_q  <= ST_WAIT;
            end
          end else if (adv_i) begin
            cnt_q    <= step_cnt;
            ahead_q  <= sh_ahead;
            behind_q <= sh_behind;
            state_q  <= sh_hit ? ST_IDLE : ST_WAIT;
          end
        end
        ST_WAIT: begin
          // never overwrite the buffer the execution side is still using
          if (exec_buf_i != cur_buf) state_q <= ST_FETCH;
        end
        ST_FETCH: begin
          if (fetch_ack_i) begin
            behind_q[cur_buf] <= 1'b1;
            state_q           <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o      = (state_q == ST_IDLE);
  assign fetch_req_o  = (state_q == ST_FETCH);
  assign la_cnt_o     = cnt_q;
  assign fetch_word_o = cnt_q[CNT_W-1:2];
  assign fetch_buf_o  = cur_buf;

  for (genvar b = 0; b < NBUF; b++) begin : g_ind
    assign ind_o[2*b+1] = ahead_q[b];
    assign ind_o[2*b]   = behind_q[b];
  end

  assert_group_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (la_cnt_o[1:0] != 2'b11 && !start_i && !jump_i) |=> la_cnt_o[1:0] != 2'b11);

  assert_fetch_waits_exec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(fetch_req_o) && !$past(start_i)) |-> ($past(exec_buf_i) != fetch_buf_o));

  assert_ack_sets_behind_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_o && fetch_ack_i && !start_i) |=> (behind_q[$past(fetch_buf_o)] && ready_o));

  assert_start_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (ind_o == '0 && fetch_req_o));

  assert_stall_holds_cnt_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !start_i) |=> $stable(la_cnt_o));
endmodule

// File: tb/test_iword_buf_tracker.sv
module test_iword_buf_tracker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [14:0] start_cnt_i = '0;
  logic        adv_i = 1'b0;
  logic        long_i = 1'b0;
  logic        jump_i = 1'b0;
  logic [14:0] jump_cnt_i = '0;
  logic [1:0]  exec_buf_i = '0;
  logic        fetch_ack_i = 1'b0;
  logic        ready_o;
  logic [14:0] la_cnt_o;
  logic [7:0]  ind_o;
  logic        fetch_req_o;
  logic [12:0] fetch_word_o;
  logic [1:0]  fetch_buf_o;

  int checks = 0;
  int failures = 0;

  logic [14:0] exp_cnt;
  logic [3:0]  exp_ah, exp_bh;

  always #(CLK_PERIOD/2) clk = ~clk;

  iword_buf_tracker i_iword_buf_tracker (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .start_cnt_i(start_cnt_i),
    .adv_i(adv_i), .long_i(long_i), .jump_i(jump_i), .jump_cnt_i(jump_cnt_i),
    .exec_buf_i(exec_buf_i), .fetch_ack_i(fetch_ack_i), .ready_o(ready_o),
    .la_cnt_o(la_cnt_o), .ind_o(ind_o), .fetch_req_o(fetch_req_o),
    .fetch_word_o(fetch_word_o), .fetch_buf_o(fetch_buf_o)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_ind();
    logic [7:0] v;
    for (int b = 0; b < 4; b++) begin
      v[2*b+1] = exp_ah[b];
      v[2*b]   = exp_bh[b];
    end
    return v;
  endfunction

  function automatic logic [14:0] inc1(input logic [14:0] c);
    if (c[1:0] == 2'd2) return {c[14:2] + 13'd1, 2'b00};
    return c + 15'd1;
  endfunction

  // returns hit
  function automatic logic slide(input int base, input int d);
    int idx;
    int mag;
    idx = base;
    mag = (d < 0) ? -d : d;
    for (int k = 1; k <= mag; k++) begin
      idx = (d < 0) ? (base - k + 16) % 4 : (base + k) % 4;
      if (d < 0) begin exp_ah[idx] = exp_bh[idx]; exp_bh[idx] = 1'b0; end
      else       begin exp_bh[idx] = exp_ah[idx]; exp_ah[idx] = 1'b0; end
    end
    if (mag == 0) return 1'b1;
    return (d < 0) ? exp_ah[idx] : exp_bh[idx];
  endfunction

  task automatic check_state(input string req, input logic exp_ready);
    check(req, "cnt", 32'(la_cnt_o), 32'(exp_cnt));
    check(req, "ind", 32'(ind_o), 32'(exp_ind()));
    check(req, "ready", 32'(ready_o), 32'(exp_ready));
  endtask

  task automatic ack_cycle();
    fetch_ack_i = 1'b1;
    @(negedge clk);
    fetch_ack_i = 1'b0;
    exp_bh[exp_cnt[3:2]] = 1'b1;
    check_state("R5", 1'b1);
    check("R5", "req_after_ack", 32'(fetch_req_o), 32'd0);
  endtask

  task automatic serve_miss();
    exec_buf_i = exp_cnt[3:2];
    adv_i = 1'b1; long_i = 1'b1; jump_i = 1'b1; jump_cnt_i = exp_cnt + 15'd40;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      check("R4", "req_held", 32'(fetch_req_o), 32'd0);
      check_state("R11", 1'b0);
    end
    adv_i = 1'b0; long_i = 1'b0; jump_i = 1'b0;
    exec_buf_i = exp_cnt[3:2] + 2'd1;
    @(negedge clk);
    check("R4", "req", 32'(fetch_req_o), 32'd1);
    check("R4", "word", 32'(fetch_word_o), 32'(exp_cnt[14:2]));
    check("R4", "buf", 32'(fetch_buf_o), 32'(exp_cnt[3:2]));
    ack_cycle();
  endtask

  task automatic do_start(input logic [14:0] c);
    start_i = 1'b1; start_cnt_i = c; exec_buf_i = c[3:2];
    @(negedge clk);
    start_i = 1'b0;
    exp_cnt = c; exp_ah = '0; exp_bh = '0;
    check_state("R10", 1'b0);
    check("R10", "req", 32'(fetch_req_o), 32'd1);
    ack_cycle();
  endtask

  task automatic do_adv(input logic lng);
    logic [14:0] n;
    logic hit;
    n = inc1(exp_cnt);
    if (lng) n = inc1(n);
    hit = 1'b1;
    if (n[14:2] != exp_cnt[14:2]) hit = slide(int'(exp_cnt[3:2]), 1);
    exp_cnt = n;
    adv_i = 1'b1; long_i = lng;
    @(negedge clk);
    adv_i = 1'b0; long_i = 1'b0;
    check_state(hit ? "R2" : "R3", hit);
    if (!hit) serve_miss();
  endtask

  task automatic do_jump(input int d, input logic [1:0] grp);
    logic [14:0] t;
    logic hit;
    string r;
    t = {exp_cnt[14:2] + 13'(d), grp};
    if (d > 6 || d < -6) begin
      exp_ah = '0; exp_bh = '0; hit = 1'b0; r = "R8";
    end else begin
      hit = slide(int'(exp_cnt[3:2]), d);
      r = (d == 0) ? "R9" : (d > 0) ? "R6" : "R7";
    end
    exp_cnt = t;
    jump_i = 1'b1; jump_cnt_i = t; adv_i = 1'b1;
    @(negedge clk);
    jump_i = 1'b0; adv_i = 1'b0;
    check_state(r, hit);
    if (!hit) serve_miss();
  endtask

  initial begin
    repeat (CLK_PERIOD * 15000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    exp_cnt = '0; exp_ah = '0; exp_bh = '0;
    check_state("R1", 1'b1);
    check("R1", "req", 32'(fetch_req_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int o = 0; o < 4; o++) begin
      for (int d1 = -8; d1 <= 8; d1++) begin
        for (int d2 = -8; d2 <= 8; d2++) begin
          do_start({13'(40 + o), 2'b00});
          do_adv(1'b0);
          do_adv(1'b1);
          do_adv(1'b0);
          do_adv(1'b1);
          do_jump(d1, 2'((d1 + 9) % 3));
          do_jump(d2, 2'((d2 + 10) % 3));
          do_adv(1'b1);
          do_adv(1'b0);
        end
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule